// File: doc/BRIEF.md
# Compare-Value Timer with Relative Downcounter View

This block is a physical timer that watches a free-running 64-bit system count supplied from outside. It keeps a 64-bit compare value together with an enable and a mask bit. Once the count has reached the compare value, it raises a timer-condition output. It also raises a level interrupt request unless that request is masked.

Software reaches the timer through a small register port with two views of the same deadline. The absolute view reads and writes the compare value directly. The relative view behaves like a signed 32-bit downcounter, but no such counter is stored. A read returns the compare value minus the current count. A write turns the signed 32-bit value into an absolute deadline by sign-extending it and adding the current count.

An optional offset path, chosen by a parameter and switched at run time, subtracts a 64-bit offset from the count. This gives a virtualised time base, and that base is then used for every view and for the condition test.

Top module: `cmp_timer`

## Requirements
- R1: A write to address 2 (relative view) sets the compare value to the effective count plus wdata[31:0] sign-extended to 64 bits; wdata[63:32] has no effect.
- R2: While enabled, a read of address 2 returns zero in bits [63:32] and the low 32 bits of (compare value minus effective count) in bits [31:0].
- R3: While disabled, a read of address 2 returns all zeros.
- R4: Address 1 (absolute view) reads and writes the full 64-bit compare value.
- R5: tmr_cond is a register that, one clock after a given state, is 1 exactly when the enable bit is 1 and the effective count is greater than or equal to the compare value as unsigned 64-bit numbers. It is 0 while the timer is disabled.
- R6: irq is registered in step with tmr_cond and equals the timer condition with the mask bit clear; a set mask forces irq low.
- R7: Address 0 is the control register: bit 0 enable, bit 1 mask (read/write), bit 2 a read-only copy of tmr_cond that ignores the mask; writes to bit 2 are ignored and all other bits read as zero.
- R8: With the offset path built (OFFSET_EN=1) and offset_on high, the effective count is sys_count minus offset_val. This count is used for R1, R2 and R5. With offset_on low, the effective count is sys_count.
- R9: After reset the enable bit, the mask bit and the compare value are 0, and tmr_cond and irq are low.
- R10: Switching the enable bit leaves the compare value untouched, so after re-enabling, a relative read includes the count that elapsed while the timer was disabled.
- R11: Address 3 reads as zero and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_count | input | CNT_W | Free-running system count |
| offset_on | input | 1 | Selects the offset-adjusted count |
| offset_val | input | CNT_W | Offset subtracted from the count |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | CNT_W | Register write data |
| rdata | output | CNT_W | Register read data (combinational on addr) |
| tmr_cond | output | 1 | Timer condition met |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the same clock edge: a write that moves the deadline and the registered evaluation of the condition. The bench fires the interrupt against a deadline at zero and then writes a positive relative value. It expects irq to still read high at the falling edge that follows the write, because the flop sampled the old compare value, and to read low one cycle later. A mask write on a live interrupt is tested the same way. A table of count and relative-write pairs covers sign extension, the equality boundary and wrap-around.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
   // register addresses
   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_CMP  = 1;
   localparam int unsigned A_REL  = 2;
   // control bit positions
   localparam int unsigned B_EN   = 0;
   localparam int unsigned B_MASK = 1;
   localparam int unsigned B_STAT = 2;
endpackage

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
   parameter int unsigned CNT_W     = 64,
   parameter bit          OFFSET_EN = 1'b1
) (
   input  logic [CNT_W-1:0] sys_count,
   input  logic             offset_on,
   input  logic [CNT_W-1:0] offset_val,
   output logic [CNT_W-1:0] eff_cnt
);
   generate
      if (OFFSET_EN) begin : g_off
         assign eff_cnt = offset_on ? (sys_count - offset_val) : sys_count;
      end else begin : g_plain
         logic unused_off;
         assign unused_off = ^{offset_on, offset_val};
         assign eff_cnt    = sys_count;
      end
   endgenerate
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned TV_W   = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  eff_cnt,
   output logic              en_q,
   output logic              mask_q,
   output logic [CNT_W-1:0]  cmp_q
);
   localparam int unsigned EXT_W = CNT_W - TV_W;

   logic [CNT_W-1:0] rel_sext;
   assign rel_sext = {{EXT_W{wdata[TV_W-1]}}, wdata[TV_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= 1'b0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            ADDR_W'(A_CTRL): begin
               en_q   <= wdata[B_EN];
               mask_q <= wdata[B_MASK];
            end
            ADDR_W'(A_CMP): cmp_q <= wdata;
            ADDR_W'(A_REL): cmp_q <= eff_cnt + rel_sext;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cmp_timer_cond.sv
module cmp_timer_cond #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] eff_cnt,
   input  logic [CNT_W-1:0] cmp_q,
   input  logic             en_q,
   input  logic             mask_q,
   output logic             cond_q,
   output logic             irq_q
);
   logic reached;
   assign reached = (eff_cnt >= cmp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         cond_q <= en_q & reached;
         irq_q  <= en_q & reached & ~mask_q;
      end
   end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned TV_W      = 32,
   parameter int unsigned ADDR_W    = 2,
   parameter bit          OFFSET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  sys_count,
   input  logic              offset_on,
   input  logic [CNT_W-1:0]  offset_val,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              tmr_cond,
   output logic              irq
);
   localparam int unsigned HI_W = CNT_W - TV_W;

   generate
      if (TV_W >= CNT_W || TV_W < 2) begin : g_bad_tv
         $error("cmp_timer: TV_W must be at least 2 and below CNT_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("cmp_timer: ADDR_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] eff_cnt;
   logic [CNT_W-1:0] cmp_q;
   logic             en_q;
   logic             mask_q;
   logic             cond_q;
   logic             irq_q;
   logic [TV_W-1:0]  rel_lo;

   cmp_timer_count #(.CNT_W(CNT_W), .OFFSET_EN(OFFSET_EN)) u_count (
      .sys_count (sys_count),
      .offset_on (offset_on),
      .offset_val(offset_val),
      .eff_cnt   (eff_cnt)
   );

   cmp_timer_regs #(.CNT_W(CNT_W), .TV_W(TV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .eff_cnt(eff_cnt),
      .en_q   (en_q),
      .mask_q (mask_q),
      .cmp_q  (cmp_q)
   );

   cmp_timer_cond #(.CNT_W(CNT_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .eff_cnt(eff_cnt),
      .cmp_q  (cmp_q),
      .en_q   (en_q),
      .mask_q (mask_q),
      .cond_q (cond_q),
      .irq_q  (irq_q)
   );

   // only the low bits of the difference are visible
   assign rel_lo = cmp_q[TV_W-1:0] - eff_cnt[TV_W-1:0];

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(A_CTRL): begin
            rdata[B_EN]   = en_q;
            rdata[B_MASK] = mask_q;
            rdata[B_STAT] = cond_q;
         end
         ADDR_W'(A_CMP): rdata = cmp_q;
         ADDR_W'(A_REL): rdata = en_q ? {{HI_W{1'b0}}, rel_lo} : '0;
         default: rdata = '0;
      endcase
   end

   assign tmr_cond = cond_q;
   assign irq      = irq_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
   import cmp_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned TV_W   = 32,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  wdata,
   input logic [CNT_W-1:0]  rdata,
   input logic              tmr_cond,
   input logic              irq,
   input logic              en_q,
   input logic              mask_q,
   input logic [CNT_W-1:0]  cmp_q,
   input logic [CNT_W-1:0]  eff_cnt
);
   localparam int unsigned HI_W = CNT_W - TV_W;

   // R6
   irq_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> tmr_cond);

   // R6
   mask_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |=> !irq);

   // R5
   off_no_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !tmr_cond);

   // R2
   rel_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(A_REL)) |-> (rdata[CNT_W-1:TV_W] == '0));

   // R3
   rel_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(A_REL) && !en_q) |-> (rdata == '0));

   // R1
   rel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_REL)) |=>
         ((cmp_q - $past(eff_cnt)) ==
          {{HI_W{$past(wdata[TV_W-1])}}, $past(wdata[TV_W-1:0])}));

   // R7
   stat_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(A_CTRL)) |-> (rdata[B_STAT] == tmr_cond));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .TV_W(TV_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .tmr_cond(tmr_cond),
   .irq     (irq),
   .en_q    (en_q),
   .mask_q  (mask_q),
   .cmp_q   (cmp_q),
   .eff_cnt (eff_cnt)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] cnt;
   logic        offset_on;
   logic [63:0] offset_val;
   logic        wr_en;
   logic [1:0]  addr;
   logic [63:0] wdata;
   logic [63:0] rdata;
   logic        tmr_cond;
   logic        irq;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   cmp_timer u_cmp_timer (
      .clk(clk), .rst_n(rst_n), .sys_count(cnt), .offset_on(offset_on),
      .offset_val(offset_val), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tmr_cond(tmr_cond), .irq(irq)
   );

   // table: count at write, relative value, expected compare, expected condition
   localparam int NV = 6;
   localparam logic [63:0] T_CNT [NV] = '{64'd100, 64'd100, 64'd100,
      64'h1_0000_0000, 64'h1_0000_0000, 64'hFFFF_FFFF_FFFF_FFF0};
   localparam logic [31:0] T_W [NV] = '{32'd50, 32'hFFFF_FFF6, 32'd0,
      32'h7FFF_FFFF, 32'h8000_0000, 32'h20};
   localparam logic [63:0] T_CMP [NV] = '{64'd150, 64'd90, 64'd100,
      64'h1_7FFF_FFFF, 64'h0_8000_0000, 64'h10};
   localparam logic T_CND [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [63:0] d);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [63:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   initial begin
      #(200000 * 8);
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

   initial begin
      logic [63:0] v;
      rst_n = 1'b0; cnt = '0; offset_on = 1'b0; offset_val = '0;
      wr_en = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc();

      // R9 reset state
      rd(2'd0, v); chk("R9 ctrl", v, 64'd0);
      rd(2'd1, v); chk("R9 cmp", v, 64'd0);
      chk("R9 cond", {63'd0, tmr_cond}, 64'd0);
      chk("R9 irq", {63'd0, irq}, 64'd0);
      rd(2'd2, v); chk("R3 rel disabled", v, 64'd0);

      // table walk: R1 R2 R5 R6
      wr(2'd0, 64'h1);
      for (int i = 0; i < NV; i++) begin
         cnt = T_CNT[i];
         wr(2'd2, {32'hDEAD_BEEF, T_W[i]});
         rd(2'd1, v); chk("R1 rel write", v, T_CMP[i]);
         rd(2'd2, v); chk("R2 rel read", v, {32'd0, T_W[i]});
         cyc();
         chk("R5 cond", {63'd0, tmr_cond}, {63'd0, T_CND[i]});
         chk("R6 irq", {63'd0, irq}, {63'd0, T_CND[i]});
      end

      // same cycle: deadline write against live condition
      cnt = 64'd5000;
      wr(2'd1, 64'd0);
      cyc();
      chk("R6 irq live", {63'd0, irq}, 64'd1);
      wr(2'd2, 64'd100);
      chk("R5 old cmp sampled", {63'd0, irq}, 64'd1);
      cyc();
      chk("R5 new cmp", {63'd0, tmr_cond}, 64'd0);
      chk("R6 irq drop", {63'd0, irq}, 64'd0);

      // mask and status
      wr(2'd1, 64'd0);
      cyc();
      wr(2'd0, 64'h3);
      chk("R6 mask lag", {63'd0, irq}, 64'd1);
      cyc();
      chk("R6 masked irq", {63'd0, irq}, 64'd0);
      chk("R5 cond masked", {63'd0, tmr_cond}, 64'd1);
      rd(2'd0, v); chk("R7 ctrl status", v, 64'h7);
      wr(2'd0, 64'h4);
      cyc();
      rd(2'd0, v); chk("R7 stat ro", v, 64'h0);

      // elapsed time while disabled
      wr(2'd0, 64'h1);
      cnt = 64'd2000;
      wr(2'd2, 64'd300);
      wr(2'd0, 64'h0);
      rd(2'd2, v); chk("R3 rel disabled", v, 64'd0);
      cnt = 64'd2100;
      cyc();
      chk("R5 disabled cond", {63'd0, tmr_cond}, 64'd0);
      wr(2'd0, 64'h1);
      rd(2'd2, v); chk("R10 elapsed", v, 64'd200);

      // offset path
      offset_on = 1'b1; offset_val = 64'd1000; cnt = 64'd1500;
      wr(2'd2, 64'd10);
      rd(2'd1, v); chk("R8 cmp", v, 64'd510);
      rd(2'd2, v); chk("R8 rel", v, 64'd10);
      cyc();
      chk("R8 cond low", {63'd0, tmr_cond}, 64'd0);
      cnt = 64'd1510;
      cyc();
      chk("R8 cond high", {63'd0, tmr_cond}, 64'd1);
      offset_on = 1'b0;
      rd(2'd2, v); chk("R8 offset off", v, 64'h0000_0000_FFFF_FC18);

      // absolute view and unused address
      wr(2'd1, 64'h0123_4567_89AB_CDEF);
      rd(2'd1, v); chk("R4 abs", v, 64'h0123_4567_89AB_CDEF);
      wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
      rd(2'd1, v); chk("R11 cmp kept", v, 64'h0123_4567_89AB_CDEF);
      rd(2'd0, v); chk("R11 ctrl kept", v, 64'h1);
      rd(2'd3, v); chk("R11 read zero", v, 64'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule